// File: doc/BRIEF.md
# Bidirectional Port Controller with Latch-Aware Readback

This block controls an 8-bit bank of general-purpose pins for a small controller. Three registers sit on a simple register bus: an output latch, a direction mask and a pull-up mask. Each bit drives its pad through separate output, output-enable and pull-up-enable lines, and each bit samples the pad level through a two-flop synchronizer. Two kinds of read reach the latch address. A plain read returns the synchronized pin level. A read flagged as part of a read-modify-write sequence returns the latch, so that setting or clearing one bit does not corrupt the others.

An alternate function, such as a display segment driver or a peripheral output, can take over any pin through per-bit override inputs. Pins that are shared with a display driver open their input buffer only when that pin's display select is low and a global port-input enable is high. A standby input freezes the port. The pin-state select decides whether the pins float or keep their last driven state. In both cases the input path is closed.

The bus has no back-pressure. A write completes on the clock edge where its strobe is high. Read data is combinational while the read strobe is high. No pin carries a valid/ready handshake.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 0 makes the pin an input (pad_oe low). A direction bit of 1 drives pad_out from the latch bit with pad_oe high, unless standby or an override applies.
- R2: A write to address 0 always updates the latch, including bits configured as inputs and writes made during standby. The new value appears on pad_out only for bits that drive.
- R3: Address map: 0 is the latch, 1 is direction, 2 is pull-up, 3 reads 0. A plain read of address 0 returns the pad level after two clock edges of synchronization. A read of address 0 with rd_rmw high returns the latch.
- R4: After reset the latch, direction and pull-up registers are all 0 and pad_oe is 0 on every bit.
- R5: With stby high and stby_hiz high, pad_oe is 0 on every bit and pad_pu follows the pull-up register. A plain read of address 0 returns 0 once two clock edges have passed in standby.
- R6: With stby high and stby_hiz low, pad_out and pad_oe keep the values they had on the cycle before standby began, even when the latch is written. The input path is blocked as in R5.
- R7: pad_pu equals the pull-up bit, except that it is 0 while the pin drives low (pad_oe high and pad_out low).
- R8: Outside standby, an alt_oe bit of 1 forces pad_oe high and drives alt_out instead of the latch. A plain read then returns the driven value.
- R9: For pins marked in LCD_MASK (default 8'h0F, bits 0 to 3), the input is enabled only when lcd_sel is 0 for that pin and port_in_en is 1. Otherwise the pin reads 0. Pins not in the mask ignore lcd_sel and port_in_en.
- R10: With rd_en low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_rmw | input | 1 | Marks the read as part of a read-modify-write sequence |
| rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| alt_oe | input | 8 | Per-pin alternate output enable |
| alt_out | input | 8 | Per-pin alternate output value |
| lcd_sel | input | 8 | Per-pin display select for shared pins |
| port_in_en | input | 1 | Global input enable for display-shared pins |
| stby | input | 1 | Stop or watch standby active |
| stby_hiz | input | 1 | Pin-state select in standby: 1 floats the pins, 0 holds them |

## Verification
The bench builds the port with the default WIDTH of 8 and LCD_MASK of 8'h0F. With that mask, half the pins are display-shared and half are plain. A single random read therefore exercises the gated and the ungated input paths at the same time, so a mask applied to the wrong half shows up in any mixed pattern. The pad loops back through the bench. As a result, the pin-level reads for driven bits and for overridden bits reach the same synchronizer that external levels use, in both hold and float standby.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_pkg::reg_sel_e sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pull_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        gpio_pkg::REG_DATA: latch_q <= wdata;
        gpio_pkg::REG_DIR:  dir_q   <= wdata;
        gpio_pkg::REG_PULL: pull_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] LCD_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] lcd_sel,
  input  logic             port_in_en,
  input  logic             stby,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] gated;
  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam bit SHARED = LCD_MASK[i];
    logic buf_en;
    if (SHARED) begin : g_shared
      assign buf_en = !lcd_sel[i] && port_in_en;
    end else begin : g_plain
      assign buf_en = 1'b1 | (lcd_sel[i] & port_in_en);
    end
    assign gated[i] = pad_in[i] & buf_en & !stby;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      pin_sync <= '0;
    end else begin
      stage1   <= gated;
      pin_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             stby,
  input  logic             stby_hiz,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  logic [WIDTH-1:0] live_out, live_oe;
  logic [WIDTH-1:0] held_out, held_oe;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign live_oe[i]  = alt_oe[i] | dir_q[i];
    assign live_out[i] = alt_oe[i] ? alt_out[i] : latch_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_out <= '0;
      held_oe  <= '0;
    end else if (!stby) begin
      held_out <= live_out;
      held_oe  <= live_oe;
    end
  end

  always_comb begin
    if (!stby) begin
      pad_out = live_out;
      pad_oe  = live_oe;
    end else if (stby_hiz) begin
      pad_out = '0;
      pad_oe  = '0;
    end else begin
      pad_out = held_out;
      pad_oe  = held_oe;
    end
    pad_pu = pull_q & ~(pad_oe & ~pad_out);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] LCD_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic             rd_rmw,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] lcd_sel,
  input  logic             port_in_en,
  input  logic             stby,
  input  logic             stby_hiz
);
  gpio_pkg::reg_sel_e sel;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync;

  assign sel = gpio_pkg::reg_sel_e'(addr);

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .LCD_MASK(LCD_MASK)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lcd_sel(lcd_sel),
    .port_in_en(port_in_en), .stby(stby), .pin_sync(pin_sync)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
    .pull_q(pull_q), .alt_oe(alt_oe), .alt_out(alt_out), .stby(stby),
    .stby_hiz(stby_hiz), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        gpio_pkg::REG_DATA: rdata = rd_rmw ? latch_q : pin_sync;
        gpio_pkg::REG_DIR:  rdata = dir_q;
        gpio_pkg::REG_PULL: rdata = pull_q;
        default:            rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [WIDTH-1:0] wdata,
  input logic             rd_en,
  input logic             rd_rmw,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] alt_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic             stby,
  input logic             stby_hiz
);
  p_input_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && alt_oe == '0) |-> pad_oe == dir_q);

  p_rmw_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(addr) == 2'd0 && rd_en && rd_rmw && addr == 2'd0)
      |-> rdata == $past(wdata));

  p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && stby_hiz) |-> pad_oe == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && !stby_hiz && $past(stby && !stby_hiz))
      |-> ($stable(pad_out) && $stable(pad_oe)));

  p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && $past(stby) && $past(stby, 2) && rd_en && !rd_rmw && addr == 2'd0)
      |-> rdata == '0);

  p_pull_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~pad_out) == '0);

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rd_rmw(rd_rmw), .rdata(rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_oe(alt_oe), .dir_q(dir_q),
  .stby(stby), .stby_hiz(stby_hiz)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/100ps
module tb_gpio_port;
  localparam logic [7:0] MASK = 8'h0F;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, rd_rmw = 0, port_in_en = 1, stby = 0, stby_hiz = 0;
  logic [7:0] wdata = 0, rdata, pad_in, pad_out, pad_oe, pad_pu;
  logic [7:0] alt_oe = 0, alt_out = 0, lcd_sel = 0, ext = 0;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m_data, m_dir, m_pull;

  always #2.5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rd_rmw(rd_rmw), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_oe(alt_oe),
    .alt_out(alt_out), .lcd_sel(lcd_sel), .port_in_en(port_in_en),
    .stby(stby), .stby_hiz(stby_hiz)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; rd_rmw = rmw;
    #1 d = rdata;
    rd_en = 0; rd_rmw = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] f_oe(logic [7:0] ao, logic [7:0] dr);
    return ao | dr;
  endfunction
  function automatic logic [7:0] f_out(logic [7:0] ao, logic [7:0] av, logic [7:0] dt);
    return (ao & av) | (~ao & dt);
  endfunction
  function automatic logic [7:0] f_pu(logic [7:0] pl, logic [7:0] oe, logic [7:0] o);
    return pl & ~(oe & ~o);
  endfunction
  function automatic logic [7:0] f_read(logic [7:0] oe, logic [7:0] o, logic [7:0] e,
                                        logic [7:0] ls, logic pie);
    logic [7:0] en = ~MASK | (~ls & {8{pie}});
    return ((oe & o) | (~oe & e)) & en;
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] h_out, h_oe;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4: reset state
    check("R4 oe", pad_oe, 8'h00);
    rd(2'd0, 1, d); check("R4 latch", d, 8'h00);
    rd(2'd1, 0, d); check("R4 dir", d, 8'h00);
    rd(2'd2, 0, d); check("R4 pull", d, 8'h00);

    // R1 R2 R3: input pin keeps latch private
    ext = 8'h3C;
    wr(2'd0, 8'hA5);
    settle();
    check("R1 input oe", pad_oe, 8'h00);
    rd(2'd0, 1, d); check("R2 R3 rmw latch", d, 8'hA5);
    rd(2'd0, 0, d); check("R3 pin read", d, 8'h3C);
    // R3: two-edge lag
    @(negedge clk); ext = 8'hC3;
    @(negedge clk);
    rd_en = 1; addr = 0; #1 check("R3 lag old", rdata, 8'h3C); rd_en = 0;
    @(negedge clk);
    rd_en = 1; #1 check("R3 lag new", rdata, 8'hC3); rd_en = 0;
    // R10 / address 3
    #1 check("R10 idle", rdata, 8'h00);
    rd(2'd3, 0, d); check("R3 addr3", d, 8'h00);

    // R1 output drive, R7 pull-up
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    settle();
    check("R1 out", pad_out, 8'hA5);
    check("R1 oe", pad_oe, 8'hFF);
    check("R7 pull drive", pad_pu, 8'hA5);
    rd(2'd0, 0, d); check("R3 loop read", d, 8'hA5);
    wr(2'd1, 8'h00);
    @(negedge clk);
    check("R7 pull input", pad_pu, 8'hFF);

    // R8 override
    alt_oe = 8'hF0; alt_out = 8'h30; ext = 8'h0F;
    settle();
    check("R8 oe", pad_oe, 8'hF0);
    check("R8 out", pad_out & 8'hF0, 8'h30);
    rd(2'd0, 0, d); check("R8 read", d, 8'h3F);
    alt_oe = 0;

    // R9 display-shared gating
    ext = 8'hFF; lcd_sel = 8'h05;
    settle();
    rd(2'd0, 0, d); check("R9 sel", d, 8'hFA);
    port_in_en = 0;
    settle();
    rd(2'd0, 0, d); check("R9 global", d, 8'hF0);
    lcd_sel = 8'hF0; port_in_en = 1;
    settle();
    rd(2'd0, 0, d); check("R9 plain ignore", d, 8'hFF);
    lcd_sel = 0;

    // R6 hold standby
    wr(2'd2, 8'h81);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hFF);
    @(negedge clk);
    stby = 1; stby_hiz = 0;
    wr(2'd0, 8'h00);
    settle();
    check("R6 hold out", pad_out, 8'h5A);
    check("R6 hold oe", pad_oe, 8'hFF);
    rd(2'd0, 0, d); check("R6 blocked", d, 8'h00);
    rd(2'd0, 1, d); check("R2 stby write", d, 8'h00);
    // R5 float standby
    stby_hiz = 1;
    @(negedge clk);
    check("R5 oe", pad_oe, 8'h00);
    check("R5 pu", pad_pu, 8'h81);
    rd(2'd0, 0, d); check("R5 blocked", d, 8'h00);
    stby = 0; stby_hiz = 0;
    @(negedge clk);
    check("R2 exit out", pad_out, 8'h00);

    // Random sweep
    for (int it = 0; it < 300; it++) begin
      m_data = 8'($urandom); m_dir = 8'($urandom); m_pull = 8'($urandom);
      @(negedge clk);
      alt_oe = 8'($urandom); alt_out = 8'($urandom); lcd_sel = 8'($urandom);
      port_in_en = 1'($urandom); ext = 8'($urandom);
      wr(2'd0, m_data); wr(2'd1, m_dir); wr(2'd2, m_pull);
      settle();
      h_oe  = f_oe(alt_oe, m_dir);
      h_out = f_out(alt_oe, alt_out, m_data);
      check("R1 R8 rnd oe", pad_oe, h_oe);
      check("R1 R8 rnd out", pad_out & h_oe, h_out & h_oe);
      check("R7 rnd pu", pad_pu, f_pu(m_pull, h_oe, pad_out));
      rd(2'd0, 0, d); check("R3 R9 rnd read", d, f_read(h_oe, h_out, ext, lcd_sel, port_in_en));
      rd(2'd0, 1, d); check("R3 rnd rmw", d, m_data);
      rd(2'd1, 0, d); check("R3 rnd dir", d, m_dir);
      rd(2'd2, 0, d); check("R3 rnd pull", d, m_pull);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule